// File: doc/BRIEF.md
# Receiver Clock Unlock Key Matcher

This block sits beside the host register port of a serial receiver/transmitter. It keeps the receiver clock gated off after reset. The gate opens only when software issues a fixed series of ten register writes, in exact order. Some of those writes target status registers that software normally only reads.

The block watches every write cycle and compares the address and data against the next expected element of the key. A write that does not match sends the matcher back to the beginning. If that same write is the opening element of the key, it starts a fresh attempt.

When the tenth element arrives, the output `rx_clk_enable` rises and stays high until the next hardware reset. The integrating design uses this level to gate the receiver clock. Software must issue the key before it programs any other register.

Top module: `rxclk_unlock`

## Requirements
- R1: While reset is active and after it is released, `rx_clk_enable` is 0 until the full key has been accepted.
- R2: The key is ten writes, in this order. First, data 0x00 to address `LINE_CTRL_ADDR` (default 3). Next, data 0xAA, 0x55, 0xCC, 0x33, 0xA5, 0xC3, 0x5C, 0x3A, each to address `MODEM_STAT_ADDR` (default 6). Last, data 0x20 to address `LINE_STAT_ADDR` (default 5).
- R3: `rx_clk_enable` reads 1 from the clock edge that captures the tenth correct write. It reads 0 before that edge.
- R4: A write to any address other than the one expected at that point breaks the attempt. Writes issued after the break must restart the key from its first element.
- R5: A write to the expected address with the wrong data breaks the attempt in the same way.
- R6: When a write breaks the attempt, the matcher returns to the start. If that write is itself 0x00 to `LINE_CTRL_ADDR`, it counts as the first element of a new attempt.
- R7: Once set, `rx_clk_enable` stays 1 through any later writes, including a repeat of the key, until reset.
- R8: A cycle counts as a write only when `wr_en` is 1 and `rd_en` is 0. Read cycles and idle cycles never advance or break the matcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; a cycle with it high is never a write |
| addr | input | ADDR_W (3) | Register address of the access |
| wdata | input | DATA_W (8) | Write data |
| rx_clk_enable | output | 1 | Receiver clock enable level |

## Verification
The bench builds the block with its default parameters: a 3-bit address, 8-bit data, and the three key addresses at 3, 6 and 5. These defaults let the bench reach every key address and every neighbouring register in the eight-entry map. The bench can therefore interrupt the key with writes to unrelated addresses and to key addresses out of turn. Because the data width is eight bits, the bench can replace a single key byte with a near-miss value and confirm that the enable stays low. It can also confirm that a mid-key restart on the opening write leads to a successful unlock.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    // Number of writes in the unlock key
    localparam int KEY_LEN = 10;
    localparam int STEP_W  = $clog2(KEY_LEN);
    // Number of data bytes sent to the modem status address
    localparam int MID_LEN = KEY_LEN - 2;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        step_t step;
        logic  open;
    } match_state_t;

    // Data bytes carried by the middle run of the key, in order
    function automatic logic [7:0] mid_byte(input int idx);
        case (idx)
            0:       return 8'hAA;
            1:       return 8'h55;
            2:       return 8'hCC;
            3:       return 8'h33;
            4:       return 8'hA5;
            5:       return 8'hC3;
            6:       return 8'h5C;
            default: return 8'h3A;
        endcase
    endfunction

endpackage

// File: rtl/unlock_key_rom.sv
module unlock_key_rom
    import unlock_pkg::*;
#(
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int LINE_CTRL_ADDR  = 3,
    parameter int MODEM_STAT_ADDR = 6,
    parameter int LINE_STAT_ADDR  = 5,
    parameter int OPEN_BYTE       = 8'h00,
    parameter int CLOSE_BYTE      = 8'h20
) (
    input  step_t             step,
    output logic [ADDR_W-1:0] exp_addr,
    output logic [DATA_W-1:0] exp_data
);

    localparam int LAST = KEY_LEN - 1;

    always_comb begin
        if (int'(step) == 0) begin
            exp_addr = ADDR_W'(LINE_CTRL_ADDR);
            exp_data = DATA_W'(OPEN_BYTE);
        end else if (int'(step) >= LAST) begin
            exp_addr = ADDR_W'(LINE_STAT_ADDR);
            exp_data = DATA_W'(CLOSE_BYTE);
        end else begin
            exp_addr = ADDR_W'(MODEM_STAT_ADDR);
            exp_data = DATA_W'(mid_byte(int'(step) - 1));
        end
    end

endmodule

// File: rtl/unlock_matcher.sv
module unlock_matcher
    import unlock_pkg::*;
#(
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int LINE_CTRL_ADDR  = 3,
    parameter int MODEM_STAT_ADDR = 6,
    parameter int LINE_STAT_ADDR  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_q
);

    localparam int    LAST       = KEY_LEN - 1;
    localparam step_t STEP_FIRST = step_t'(0);
    localparam step_t STEP_LAST  = step_t'(LAST);

    match_state_t     st_d, st_q;
    logic [ADDR_W-1:0] cur_addr, head_addr;
    logic [DATA_W-1:0] cur_data, head_data;
    logic             hit_cur, hit_head;

    // Element expected at the current position
    unlock_key_rom #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_CTRL_ADDR(LINE_CTRL_ADDR),
        .MODEM_STAT_ADDR(MODEM_STAT_ADDR),
        .LINE_STAT_ADDR(LINE_STAT_ADDR)
    ) u_rom_cur (
        .step(st_q.step), .exp_addr(cur_addr), .exp_data(cur_data)
    );

    // Opening element, used to restart on a breaking write
    unlock_key_rom #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_CTRL_ADDR(LINE_CTRL_ADDR),
        .MODEM_STAT_ADDR(MODEM_STAT_ADDR),
        .LINE_STAT_ADDR(LINE_STAT_ADDR)
    ) u_rom_head (
        .step(STEP_FIRST), .exp_addr(head_addr), .exp_data(head_data)
    );

    assign hit_cur  = (addr == cur_addr)  && (wdata == cur_data);
    assign hit_head = (addr == head_addr) && (wdata == head_data);

    always_comb begin
        st_d = st_q;
        if (wr_vld && !st_q.open) begin
            if (hit_cur) begin
                if (st_q.step == STEP_LAST) begin
                    st_d.open = 1'b1;
                    st_d.step = STEP_FIRST;
                end else begin
                    st_d.step = st_q.step + step_t'(1);
                end
            end else if (hit_head) begin
                st_d.step = step_t'(1);
            end else begin
                st_d.step = STEP_FIRST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: STEP_FIRST, open: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign open_q = st_q.open;

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.step) < KEY_LEN); // R2

    AST_OPEN_ONLY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> ($past(st_q.step) == STEP_LAST && $past(wr_vld))); // R3

    AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !st_q.open && !hit_cur) |=> (int'(st_q.step) <= 1)); // R6

    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open |=> st_q.open); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> ($stable(st_q.step) && $stable(st_q.open))); // R8

endmodule

// File: rtl/rxclk_unlock.sv
module rxclk_unlock
    import unlock_pkg::*;
#(
    parameter int ADDR_W          = 3,
    parameter int DATA_W          = 8,
    parameter int LINE_CTRL_ADDR  = 3,
    parameter int MODEM_STAT_ADDR = 6,
    parameter int LINE_STAT_ADDR  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rx_clk_enable
);

    logic wr_vld;

    // A cycle with a read strobe is never a write
    assign wr_vld = wr_en && !rd_en;

    unlock_matcher #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINE_CTRL_ADDR(LINE_CTRL_ADDR),
        .MODEM_STAT_ADDR(MODEM_STAT_ADDR),
        .LINE_STAT_ADDR(LINE_STAT_ADDR)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld),
        .addr(addr), .wdata(wdata), .open_q(rx_clk_enable)
    );

    AST_RESET_CLOSED: assert property (@(posedge clk)
        !rst_n |=> !rx_clk_enable); // R1

endmodule

// File: tb/tb_rxclk_unlock.sv
module tb_rxclk_unlock;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rx_clk_enable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxclk_unlock dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rx_clk_enable(rx_clk_enable)
    );

    // Row: {wr, rd, addr[2:0], data[7:0], expected enable}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd3, 8'h00, 1'b0},
        {1'b0, 1'b1, 3'd6, 8'hAA, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'hAA, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'h55, 1'b0},
        {1'b0, 1'b0, 3'd1, 8'hFF, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'hCC, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'h33, 1'b0},
        {1'b1, 1'b1, 3'd2, 8'h99, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'hA5, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'hC3, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'h5C, 1'b0},
        {1'b1, 1'b0, 3'd6, 8'h3A, 1'b0},
        {1'b1, 1'b0, 3'd5, 8'h20, 1'b1},
        {1'b1, 1'b0, 3'd0, 8'h12, 1'b1}
    };

    localparam logic [7:0] KEY_MID [8] = '{8'hAA, 8'h55, 8'hCC, 8'h33,
                                           8'hA5, 8'hC3, 8'h5C, 8'h3A};

    task automatic check(input logic exp, input string req);
        checks++;
        if (rx_clk_enable !== exp) begin
            fails++;
            $display("FAIL %s: rx_clk_enable=%b expected=%b", req, rx_clk_enable, exp);
        end
    endtask

    task automatic cycle(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue key elements from index lo to hi; bad_idx replaces one byte
    task automatic send_key(input int lo, input int hi, input int bad_idx);
        for (int k = lo; k <= hi; k++) begin
            logic [2:0] a;
            logic [7:0] d;
            if (k == 0) begin a = 3'd3; d = 8'h00; end
            else if (k == 9) begin a = 3'd5; d = 8'h20; end
            else begin a = 3'd6; d = KEY_MID[k-1]; end
            if (k == bad_idx) d = d ^ 8'h01;
            cycle(1'b1, 1'b0, a, d);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: rx_clk_enable=%b expected=finish", rx_clk_enable);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: held in reset, then released
        @(negedge clk);
        check(1'b0, "R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1 after reset");

        // R2 R3 R8 R7: table walk of a correct key mixed with reads and idles
        for (int i = 0; i < NVEC; i++) begin
            cycle(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8:1]);
            check(VEC[i][0], $sformatf("R3 R8 table row %0d", i));
        end

        // R7: repeated key and junk after unlock
        send_key(0, 9, -1);
        check(1'b1, "R7 key repeated after unlock");
        cycle(1'b1, 1'b0, 3'd6, 8'h00);
        check(1'b1, "R7 junk write after unlock");

        // R5: one wrong byte in the middle
        do_reset();
        check(1'b0, "R1 after second reset");
        send_key(0, 9, 4);
        check(1'b0, "R5 wrong byte at element 4");

        // R5: wrong final byte
        do_reset();
        send_key(0, 8, -1);
        cycle(1'b1, 1'b0, 3'd5, 8'h21);
        check(1'b0, "R5 wrong final byte");

        // R4: interrupted by write to another register, then resumed
        do_reset();
        send_key(0, 4, -1);
        cycle(1'b1, 1'b0, 3'd1, 8'h0F);
        send_key(5, 9, -1);
        check(1'b0, "R4 interrupted key");

        // R4: final byte to a key address out of turn
        do_reset();
        send_key(0, 8, -1);
        cycle(1'b1, 1'b0, 3'd6, 8'h20);
        check(1'b0, "R4 final data on wrong address");

        // R6: mid-key restart with the opening write, then complete
        send_key(0, 3, -1);
        send_key(0, 9, -1);
        check(1'b1, "R6 restart on opening write");

        // R3: enable low one element short, high after the last
        do_reset();
        send_key(0, 8, -1);
        check(1'b0, "R3 nine of ten elements");
        cycle(1'b1, 1'b0, 3'd5, 8'h20);
        check(1'b1, "R3 tenth element");

        // R8: full key delivered only as reads
        do_reset();
        for (int k = 0; k < 10; k++) begin
            cycle(1'b0, 1'b1, k == 0 ? 3'd3 : (k == 9 ? 3'd5 : 3'd6),
                  k == 0 ? 8'h00 : (k == 9 ? 8'h20 : KEY_MID[k == 9 ? 0 : (k == 0 ? 0 : k-1)]));
        end
        check(1'b0, "R8 key as reads only");
        send_key(0, 9, -1);
        check(1'b1, "R8 reads left matcher at start");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule